// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clocks of a small CPU subsystem run while software is saving power. A power-save request carries a mode code: code 1 asks for idle, where only the CPU clock stops, and code 0 asks for sleep, where the CPU, system and peripheral clocks all stop. A sleep request can instead enter low-voltage sleep. This happens when a configuration permit input and a software low-voltage enable input are both high at the moment of the request. In that mode a regulator select output picks the low-voltage core supply.

The block watches three wake sources: a reset that is not a power-on reset, a watchdog overflow, and an interrupt request that carries a priority. In idle, the interrupt's priority is compared with the current CPU priority. The block decides whether the CPU picks up at the instruction after the request or vectors to a service routine, and reports this with a one-cycle resume strobe.

Leaving sleep takes a fixed number of cycles while the oscillator starts, and leaving low-voltage sleep takes longer while the regulator recovers. Both delays are plain counters. Register and memory contents are never touched by the block, so they are kept in every mode.

Top module: `lpm_sequencer`

## Requirements
- R1: After power-on reset (rstN low), cpuClkEn, sysClkEn and perClkEn are 1, lvRegSel is 0 and resumeValid is 0.
- R2: A saveReq with modeCode 2'b01 taken while running, with no wake source active, makes cpuClkEn 0 from the next cycle. sysClkEn and perClkEn stay 1.
- R3: A saveReq with modeCode 2'b00 taken while running, with no wake source active and not both lvEnable and lvPermit high, makes cpuClkEn, sysClkEn and perClkEn 0 from the next cycle, with lvRegSel 0.
- R4: A sleep request (modeCode 2'b00) with lvEnable and lvPermit both 1 enters low-voltage sleep. All three clock enables are 0 and lvRegSel is 1. With lvEnable 1 but lvPermit 0, the request enters ordinary sleep (R3).
- R5: In idle, sysReset, wdtOverflow, or irqReq with irqPrio <= cpuPrio returns all clock enables to 1 in the next cycle. resumeValid is then 1 for exactly one cycle, with resumeVector 0 (continue at the next instruction).
- R6: In idle, irqReq with irqPrio > cpuPrio (unsigned) wakes with resumeVector 1 (vector to the service routine). If sysReset or wdtOverflow is high in the same cycle, resumeVector is 0.
- R7: In sleep, any of sysReset, wdtOverflow or irqReq (any priority) starts the wake-up. The clock enables stay 0 for exactly SLEEP_DLY cycles after the wake cycle, then all return to 1 together with a resumeValid pulse that has resumeVector 0.
- R8: In low-voltage sleep, a wake source starts a wake-up of exactly LV_DLY cycles (LV_DLY > SLEEP_DLY) with the clock enables at 0. lvRegSel falls in the cycle after the wake source is seen, and resumeVector is 0.
- R9: A saveReq arriving in the same cycle as sysReset, wdtOverflow or irqReq is ignored. The clock enables stay 1.
- R10: A saveReq with modeCode 2'b10 or 2'b11 is ignored.
- R11: saveReq while not running, and wake sources during a wake-up delay, have no effect. The delay length is unchanged.
- R12: Without a wake source, idle, sleep and low-voltage sleep hold their clock enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| saveReq | input | 1 | Power-save request strobe |
| modeCode | input | 2 | Requested mode: 2'b01 idle, 2'b00 sleep |
| lvEnable | input | 1 | Software low-voltage enable bit |
| lvPermit | input | 1 | Configuration permit for the low-voltage regulator |
| sysReset | input | 1 | Non-power-on reset wake source |
| wdtOverflow | input | 1 | Watchdog overflow wake source |
| irqReq | input | 1 | Interrupt request wake source |
| irqPrio | input | PRIO_W | Priority of the pending interrupt |
| cpuPrio | input | PRIO_W | Current CPU priority |
| cpuClkEn | output | 1 | CPU clock enable |
| sysClkEn | output | 1 | System clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| lvRegSel | output | 1 | Selects the low-voltage core regulator |
| resumeValid | output | 1 | One-cycle strobe when execution resumes |
| resumeVector | output | 1 | 1: vector to the service routine, 0: next instruction |

## Verification
The hardest case to reach is a wake source, or a fresh power-save request, landing in the middle of a wake-up delay. The block must ignore it without restarting or shortening the count, so the fault only shows as the clocks coming back a few cycles early or late. The stimulus reaches it by entering sleep, waking, and then pulsing the watchdog and a new request partway through the delay. The bench then counts the exact cycle on which the clock enables return. A second hard case is a high-priority interrupt in idle that coincides with a watchdog overflow. The bench drives both in one cycle to check that the resume target falls back to the next instruction.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SLEEP   = 3'd2,
    ST_LVSLEEP = 3'd3,
    ST_WAKE    = 3'd4
  } lpState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadShort;  // start ordinary sleep wake-up delay
    logic loadLong;   // start low-voltage sleep wake-up delay
    logic doResume;   // execution restarts this cycle
    logic resumeVec;  // restart goes to the service routine
  } lpStrobe_t;

  localparam logic [1:0] MODE_SLEEP = 2'b00;
  localparam logic [1:0] MODE_IDLE  = 2'b01;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int PRIO_W    = 3,
  parameter int SLEEP_DLY = 16,
  parameter int LV_DLY    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysReset,
  input  logic              wdtOverflow,
  input  logic              irqReq,
  input  logic [PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0] cpuPrio,
  input  lpStrobe_t         strobe,
  output logic              wakeAny,
  output logic              wakeHigh,
  output logic              cntDone,
  output logic              resumeValid,
  output logic              resumeVector
);

  localparam int              CNT_W      = $clog2(LV_DLY + 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SLEEP_DLY - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LV_DLY - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  logic [CNT_W-1:0] dlyCnt;
  logic             prioAbove;

  // Wake qualification: any source ends every low-power mode
  assign prioAbove = irqPrio > cpuPrio;
  assign wakeAny   = sysReset | wdtOverflow | irqReq;
  // Vectoring only for an interrupt above CPU priority with no reset/watchdog
  assign wakeHigh  = irqReq & prioAbove & ~sysReset & ~wdtOverflow;

  // Wake-up delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (strobe.loadLong) begin
      dlyCnt <= LONG_LOAD;
    end else if (strobe.loadShort) begin
      dlyCnt <= SHORT_LOAD;
    end else if (dlyCnt != '0) begin
      dlyCnt <= dlyCnt - CNT_ONE;
    end
  end

  assign cntDone = (dlyCnt == '0);

  // Resume report
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumeValid  <= 1'b0;
      resumeVector <= 1'b0;
    end else begin
      resumeValid  <= strobe.doResume;
      resumeVector <= strobe.doResume & strobe.resumeVec;
    end
  end

  // R7/R8: the delay counts down by one each cycle once loaded
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dlyCnt != '0 && !strobe.loadShort && !strobe.loadLong)
      |=> dlyCnt == $past(dlyCnt) - CNT_ONE);

  // R8: a long load is followed by the long start value
  p_long_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLong |=> dlyCnt == LONG_LOAD);

  // R5: resume strobe lasts a single cycle
  p_resume_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |=> !resumeValid);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       saveReq,
  input  logic [1:0] modeCode,
  input  logic       lvEnable,
  input  logic       lvPermit,
  input  logic       wakeAny,
  input  logic       wakeHigh,
  input  logic       cntDone,
  output lpStrobe_t  strobe,
  output logic       cpuClkEn,
  output logic       sysClkEn,
  output logic       perClkEn,
  output logic       lvRegSel
);

  lpState_e curState, nextState;
  logic     reqIdle, reqSleep, lvAllowed;

  assign reqIdle   = saveReq & ~wakeAny & (modeCode == MODE_IDLE);
  assign reqSleep  = saveReq & ~wakeAny & (modeCode == MODE_SLEEP);
  assign lvAllowed = lvEnable & lvPermit;

  always_comb begin
    nextState = curState;
    strobe    = '0;
    unique case (curState)
      ST_RUN: begin
        if (reqIdle)       nextState = ST_IDLE;
        else if (reqSleep) nextState = lvAllowed ? ST_LVSLEEP : ST_SLEEP;
      end
      ST_IDLE: begin
        if (wakeAny) begin
          nextState        = ST_RUN;
          strobe.doResume  = 1'b1;
          strobe.resumeVec = wakeHigh;
        end
      end
      ST_SLEEP: begin
        if (wakeAny) begin
          nextState        = ST_WAKE;
          strobe.loadShort = 1'b1;
        end
      end
      ST_LVSLEEP: begin
        if (wakeAny) begin
          nextState       = ST_WAKE;
          strobe.loadLong = 1'b1;
        end
      end
      ST_WAKE: begin
        if (cntDone) begin
          nextState       = ST_RUN;
          strobe.doResume = 1'b1;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  // State and registered clock enables (glitch-free for the gating cells)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_RUN;
      cpuClkEn <= 1'b1;
      sysClkEn <= 1'b1;
      perClkEn <= 1'b1;
      lvRegSel <= 1'b0;
    end else begin
      curState <= nextState;
      cpuClkEn <= (nextState == ST_RUN);
      sysClkEn <= (nextState == ST_RUN) || (nextState == ST_IDLE);
      perClkEn <= (nextState == ST_RUN) || (nextState == ST_IDLE);
      lvRegSel <= (nextState == ST_LVSLEEP);
    end
  end

  // R2: idle request stops only the CPU clock
  p_idle_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_RUN && saveReq && !wakeAny && modeCode == MODE_IDLE)
      |=> !cpuClkEn && sysClkEn && perClkEn);

  // R9: a request alongside a wake source keeps the CPU running
  p_req_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_RUN && wakeAny) |=> cpuClkEn && curState == ST_RUN);

  // R5: idle ends in one cycle on any wake source
  p_idle_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && wakeAny) |=> cpuClkEn);

  // R4/R8: low-voltage regulator only while every clock is stopped
  p_lv_clocks_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    lvRegSel |-> !cpuClkEn && !sysClkEn && !perClkEn);

  // R12: sleep holds without a wake source
  p_sleep_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_SLEEP && !wakeAny) |=> $stable(sysClkEn) && !cpuClkEn);

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int PRIO_W    = 3,
  parameter int SLEEP_DLY = 16,
  parameter int LV_DLY    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              saveReq,
  input  logic [1:0]        modeCode,
  input  logic              lvEnable,
  input  logic              lvPermit,
  input  logic              sysReset,
  input  logic              wdtOverflow,
  input  logic              irqReq,
  input  logic [PRIO_W-1:0] irqPrio,
  input  logic [PRIO_W-1:0] cpuPrio,
  output logic              cpuClkEn,
  output logic              sysClkEn,
  output logic              perClkEn,
  output logic              lvRegSel,
  output logic              resumeValid,
  output logic              resumeVector
);

  lpStrobe_t strobe;
  logic      wakeAny, wakeHigh, cntDone;

  initial begin
    if (SLEEP_DLY < 1 || LV_DLY <= SLEEP_DLY)
      $error("lpm_sequencer: need 1 <= SLEEP_DLY < LV_DLY");
  end

  lpm_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .saveReq  (saveReq),
    .modeCode (modeCode),
    .lvEnable (lvEnable),
    .lvPermit (lvPermit),
    .wakeAny  (wakeAny),
    .wakeHigh (wakeHigh),
    .cntDone  (cntDone),
    .strobe   (strobe),
    .cpuClkEn (cpuClkEn),
    .sysClkEn (sysClkEn),
    .perClkEn (perClkEn),
    .lvRegSel (lvRegSel)
  );

  lpm_datapath #(
    .PRIO_W    (PRIO_W),
    .SLEEP_DLY (SLEEP_DLY),
    .LV_DLY    (LV_DLY)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .sysReset     (sysReset),
    .wdtOverflow  (wdtOverflow),
    .irqReq       (irqReq),
    .irqPrio      (irqPrio),
    .cpuPrio      (cpuPrio),
    .strobe       (strobe),
    .wakeAny      (wakeAny),
    .wakeHigh     (wakeHigh),
    .cntDone      (cntDone),
    .resumeValid  (resumeValid),
    .resumeVector (resumeVector)
  );

endmodule

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;

  localparam int PRIO_W = 3;
  localparam int SDLY   = 16;
  localparam int LDLY   = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic saveReq = 1'b0;
  logic [1:0] modeCode = 2'b00;
  logic lvEnable = 1'b0, lvPermit = 1'b0;
  logic sysReset = 1'b0, wdtOverflow = 1'b0, irqReq = 1'b0;
  logic [PRIO_W-1:0] irqPrio = '0, cpuPrio = '0;
  logic cpuClkEn, sysClkEn, perClkEn, lvRegSel, resumeValid, resumeVector;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lpm_sequencer #(.PRIO_W(PRIO_W), .SLEEP_DLY(SDLY), .LV_DLY(LDLY)) uut (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .modeCode(modeCode),
    .lvEnable(lvEnable), .lvPermit(lvPermit), .sysReset(sysReset),
    .wdtOverflow(wdtOverflow), .irqReq(irqReq), .irqPrio(irqPrio),
    .cpuPrio(cpuPrio), .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn),
    .perClkEn(perClkEn), .lvRegSel(lvRegSel), .resumeValid(resumeValid),
    .resumeVector(resumeVector)
  );

  // wk: 0 sysReset, 1 watchdog, 2 interrupt; eDly 0 means idle
  typedef struct packed {
    logic [1:0] mode;
    logic       lvE;
    logic       lvP;
    logic [1:0] wk;
    logic [2:0] ip;
    logic [2:0] cp;
    logic       eSys;
    logic       eLv;
    logic       eVec;
    logic [7:0] eDly;
  } scn_t;

  localparam int NS = 12;
  localparam scn_t TBL [NS] = '{
    '{2'd1, 1'b0, 1'b0, 2'd2, 3'd2, 3'd5, 1'b1, 1'b0, 1'b0, 8'd0},
    '{2'd1, 1'b0, 1'b0, 2'd2, 3'd5, 3'd5, 1'b1, 1'b0, 1'b0, 8'd0},
    '{2'd1, 1'b0, 1'b0, 2'd2, 3'd6, 3'd2, 1'b1, 1'b0, 1'b1, 8'd0},
    '{2'd1, 1'b1, 1'b1, 2'd1, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0},
    '{2'd1, 1'b0, 1'b0, 2'd0, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0, 8'd0},
    '{2'd0, 1'b0, 1'b0, 2'd2, 3'd0, 3'd7, 1'b0, 1'b0, 1'b0, 8'd16},
    '{2'd0, 1'b0, 1'b0, 2'd1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd16},
    '{2'd0, 1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'd16},
    '{2'd0, 1'b1, 1'b0, 2'd2, 3'd7, 3'd0, 1'b0, 1'b0, 1'b0, 8'd16},
    '{2'd0, 1'b0, 1'b1, 2'd2, 3'd7, 3'd0, 1'b0, 1'b0, 1'b0, 8'd16},
    '{2'd0, 1'b1, 1'b1, 2'd2, 3'd7, 3'd1, 1'b0, 1'b1, 1'b0, 8'd64},
    '{2'd0, 1'b1, 1'b1, 2'd1, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 8'd64}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chkRun(input string req);
    chk(req, "cpuClkEn", cpuClkEn, 1'b1);
    chk(req, "sysClkEn", sysClkEn, 1'b1);
    chk(req, "perClkEn", perClkEn, 1'b1);
  endtask

  task automatic request(input logic [1:0] m, input logic e, input logic p);
    @(negedge clk);
    saveReq = 1'b1; modeCode = m; lvEnable = e; lvPermit = p;
    @(negedge clk);
    saveReq = 1'b0; lvEnable = 1'b0; lvPermit = 1'b0;
  endtask

  task automatic wakeOne(input logic [1:0] wk, input logic [2:0] ip);
    @(negedge clk);
    case (wk)
      2'd0:    sysReset = 1'b1;
      2'd1:    wdtOverflow = 1'b1;
      default: begin irqReq = 1'b1; irqPrio = ip; end
    endcase
    @(negedge clk);
    sysReset = 1'b0; wdtOverflow = 1'b0; irqReq = 1'b0;
  endtask

  task automatic runScn(input scn_t s);
    string tEnt;
    tEnt = (s.eDly == 0) ? "R2" : (s.eLv ? "R4" : "R3");
    cpuPrio = s.cp;
    request(s.mode, s.lvE, s.lvP);
    chk(tEnt, "cpuClkEn entry", cpuClkEn, 1'b0);
    chk(tEnt, "sysClkEn entry", sysClkEn, s.eSys);
    chk(tEnt, "perClkEn entry", perClkEn, s.eSys);
    chk(tEnt, "lvRegSel entry", lvRegSel, s.eLv);
    repeat (3) @(negedge clk);
    chk("R12", "sysClkEn hold", sysClkEn, s.eSys);
    chk("R12", "cpuClkEn hold", cpuClkEn, 1'b0);
    wakeOne(s.wk, s.ip);
    if (s.eDly == 0) begin
      chkRun("R5");
      chk("R5", "resumeValid", resumeValid, 1'b1);
      chk("R6", "resumeVector", resumeVector, s.eVec);
    end else begin
      chk("R8", "lvRegSel after wake", lvRegSel, 1'b0);
      repeat (int'(s.eDly) - 1) @(negedge clk);
      chk("R7", "cpuClkEn last delay cycle", cpuClkEn, 1'b0);
      chk("R7", "sysClkEn last delay cycle", sysClkEn, 1'b0);
      @(negedge clk);
      chkRun(s.eLv ? "R8" : "R7");
      chk("R7", "resumeValid", resumeValid, 1'b1);
      chk("R7", "resumeVector", resumeVector, 1'b0);
    end
    @(negedge clk);
    chk("R5", "resumeValid pulse end", resumeValid, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chkRun("R1");
    chk("R1", "lvRegSel", lvRegSel, 1'b0);
    chk("R1", "resumeValid", resumeValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkRun("R1");

    for (int i = 0; i < NS; i++) runScn(TBL[i]);

    // R9: request alongside a wake source
    @(negedge clk);
    saveReq = 1'b1; modeCode = 2'b00; irqReq = 1'b1;
    @(negedge clk);
    saveReq = 1'b0; irqReq = 1'b0;
    chkRun("R9");
    @(negedge clk);
    saveReq = 1'b1; modeCode = 2'b01; wdtOverflow = 1'b1;
    @(negedge clk);
    saveReq = 1'b0; wdtOverflow = 1'b0;
    chkRun("R9");
    chk("R9", "resumeValid", resumeValid, 1'b0);

    // R10: unused mode codes
    request(2'b10, 1'b0, 1'b0);
    chkRun("R10");
    request(2'b11, 1'b1, 1'b1);
    chkRun("R10");
    chk("R10", "lvRegSel", lvRegSel, 1'b0);

    // R6: high-priority interrupt with watchdog in the same cycle
    cpuPrio = 3'd1;
    request(2'b01, 1'b0, 1'b0);
    @(negedge clk);
    irqReq = 1'b1; irqPrio = 3'd7; wdtOverflow = 1'b1;
    @(negedge clk);
    irqReq = 1'b0; wdtOverflow = 1'b0;
    chk("R6", "resumeValid", resumeValid, 1'b1);
    chk("R6", "resumeVector with watchdog", resumeVector, 1'b0);

    // R11: sleep request while idle is ignored
    request(2'b01, 1'b0, 1'b0);
    request(2'b00, 1'b0, 1'b0);
    chk("R11", "sysClkEn idle kept", sysClkEn, 1'b1);
    chk("R11", "cpuClkEn idle kept", cpuClkEn, 1'b0);
    wakeOne(2'd1, 3'd0);
    chkRun("R11");

    // R11: wake source and request during the wake-up delay
    request(2'b00, 1'b0, 1'b0);
    wakeOne(2'd2, 3'd3);
    repeat (4) @(negedge clk);
    wdtOverflow = 1'b1; saveReq = 1'b1; modeCode = 2'b01;
    @(negedge clk);
    wdtOverflow = 1'b0; saveReq = 1'b0;
    repeat (SDLY - 6) @(negedge clk);
    chk("R11", "cpuClkEn delay not restarted", cpuClkEn, 1'b0);
    @(negedge clk);
    chkRun("R11");
    chk("R11", "resumeValid", resumeValid, 1'b1);
    @(negedge clk);
    chkRun("R11");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule